// File: doc/BRIEF.md
# Dual-Strobe Up/Down Counter with Preset

This block is a small binary counter whose direction comes from two separate strobe lines rather than from a mode bit. Both strobes rest high. A rising edge on the up strobe, while the down strobe stays high, adds one to the count. A rising edge on the down strobe, while the up strobe stays high, subtracts one.

A level-sensitive clear input forces the count to zero. An active-low load input copies a four-bit data word into the count. Two active-low terminal flags report when the count sits at its top value while the up strobe is low, or at zero while the down strobe is low.

Everything runs on one system clock. Both strobes, the clear input and the load input are sampled on the rising clock edge. A strobe edge is found by comparing the present sample with the previous one. The count and both flags are registered. Each input therefore shows at the outputs one clock after the edge that samples it.

Top module: `udc_dual_strobe_counter`

## Requirements
- R1: While `clear` is sampled high, the next clock edge sets `cnt` to 0, whatever `load_n`, the strobes and `din` are doing.
- R2: With `clear` low and `load_n` sampled low, the next clock edge copies `din` into `cnt`, bit for bit. Bit 0 is the least significant bit.
- R3: With `clear` low and `load_n` high, an up-strobe rise increments `cnt` by one at the edge that samples it. A rise means `up_stb` is high now and was low at the previous sample. The down strobe must be high at that sample and must not rise in the same cycle.
- R4: With `clear` low and `load_n` high, a down-strobe rise decrements `cnt` by one at the edge that samples it. The up strobe must be high at that sample and must not rise in the same cycle.
- R5: The count is unsigned binary and wraps: 15 plus one gives 0, and 0 minus one gives 15.
- R6: When both strobes rise at the same sample, with `clear` low and `load_n` high, `cnt` holds.
- R7: A strobe rise while the other strobe is low leaves `cnt` unchanged. So does a cycle with no rise at all.
- R8: `carry_n` is low only when the newly registered `cnt` is 15 and `up_stb` was low at the same sample. In every other case it is high.
- R9: `borrow_n` is low only when the newly registered `cnt` is 0 and `dn_stb` was low at the same sample. In every other case it is high.
- R10: The synchronous `rst` sets `cnt` to 0 and both flags high. It also treats both strobes as previously high, so a strobe held high through reset does not count.
- R11: Priority runs from `rst`, to `clear`, to `load_n`, to counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low load of `din` |
| up_stb | input | 1 | Count-up strobe, idles high |
| dn_stb | input | 1 | Count-down strobe, idles high |
| din | input | 4 | Preset data |
| cnt | output | 4 | Registered count |
| carry_n | output | 1 | Active-low top-count flag |
| borrow_n | output | 1 | Active-low zero-count flag |

## Verification
The embedded properties are checked on every clock. They cover these behaviours:
- the clear, load and single-step results;
- the hold when both strobes rise together;
- that a low flag always comes with the matching count value and strobe level.

Other behaviours show up only in the bench's scenarios:
- the wraps at 15 and at 0;
- that an unqualified rise is ignored;
- that nothing counts after a reset with the strobes held high;
- that the flags do go low when their condition arises, not merely that they never go low wrongly.

The bench covers these with directed sequences, and with a seeded random mix of clears, loads and strobe patterns checked against a reference model.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_LOAD  = 3'd2,
    OP_INC   = 3'd3,
    OP_DEC   = 3'd4
  } udc_op_e;
endpackage

// File: rtl/udc_strobe_edge.sv
module udc_strobe_edge #(
  parameter int LINES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] lvl,
  output logic [LINES-1:0] rise
);
  logic [LINES-1:0] prev_q;

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      always_ff @(posedge clk) begin
        if (rst) prev_q[i] <= 1'b1;
        else     prev_q[i] <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~prev_q[i];
    end
  endgenerate
endmodule

// File: rtl/udc_count_core.sv
module udc_count_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic             up_rise,
  input  logic             dn_rise,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt_d,
  output logic [WIDTH-1:0] cnt_q
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  udc_op_e op;

  always_comb begin
    if (clear)                              op = OP_CLEAR;
    else if (!load_n)                       op = OP_LOAD;
    else if (up_rise && dn_lvl && !dn_rise) op = OP_INC;
    else if (dn_rise && up_lvl && !up_rise) op = OP_DEC;
    else                                    op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: cnt_d = '0;
      OP_LOAD:  cnt_d = din;
      OP_INC:   cnt_d = cnt_q + ONE;
      OP_DEC:   cnt_d = cnt_q - ONE;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> cnt_q == '0); // R1
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> cnt_q == $past(din)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && dn_lvl && !dn_rise) |=> cnt_q == $past(cnt_q) + ONE); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && dn_rise && up_lvl && !up_rise) |=> cnt_q == $past(cnt_q) - ONE); // R4
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && dn_rise) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/udc_term_decode.sv
module udc_term_decode #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cnt_d,
  input  logic [WIDTH-1:0] cnt_q,
  input  logic             up_lvl,
  input  logic             dn_lvl,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_n  <= 1'b1;
      borrow_n <= 1'b1;
    end else begin
      carry_n  <= ~((cnt_d == TOP) & ~up_lvl);
      borrow_n <= ~((cnt_d == '0) & ~dn_lvl);
    end
  end

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    !carry_n |-> (cnt_q == TOP) && !$past(up_lvl)); // R8
  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !borrow_n |-> (cnt_q == '0) && !$past(dn_lvl)); // R9
endmodule

// File: rtl/udc_dual_strobe_counter.sv
module udc_dual_strobe_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             load_n,
  input  logic             up_stb,
  input  logic             dn_stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] cnt,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int LINES = 2;

  logic [LINES-1:0] rise;
  logic [WIDTH-1:0] cnt_d;

  udc_strobe_edge #(.LINES(LINES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl  ({dn_stb, up_stb}),
    .rise (rise)
  );

  udc_count_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .load_n  (load_n),
    .up_rise (rise[0]),
    .dn_rise (rise[1]),
    .up_lvl  (up_stb),
    .dn_lvl  (dn_stb),
    .din     (din),
    .cnt_d   (cnt_d),
    .cnt_q   (cnt)
  );

  udc_term_decode #(.WIDTH(WIDTH)) u_term (
    .clk      (clk),
    .rst      (rst),
    .cnt_d    (cnt_d),
    .cnt_q    (cnt),
    .up_lvl   (up_stb),
    .dn_lvl   (dn_stb),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt == '0) && carry_n && borrow_n); // R10
  AST_CLEAR_OVER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (clear && !load_n) |=> cnt == '0); // R11
endmodule

// File: tb/udc_dual_strobe_counter_test.sv
`timescale 1ns/1ps
module udc_dual_strobe_counter_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic       load_n = 1'b1;
  logic       up_stb = 1'b1;
  logic       dn_stb = 1'b1;
  logic [3:0] din = 4'd0;
  logic [3:0] cnt;
  logic       carry_n, borrow_n;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [3:0] m_cnt = 4'd0;
  logic       m_carry = 1'b1, m_borrow = 1'b1;
  logic       m_pu = 1'b1, m_pd = 1'b1;
  string      m_tag = "R10";

  always #2.5 clk = ~clk;

  udc_dual_strobe_counter uut (
    .clk(clk), .rst(rst), .clear(clear), .load_n(load_n),
    .up_stb(up_stb), .dn_stb(dn_stb), .din(din),
    .cnt(cnt), .carry_n(carry_n), .borrow_n(borrow_n)
  );

  // Reference model: next count computed from the requirements
  function automatic logic [3:0] next_cnt(logic c, logic l, logic u, logic d,
                                          logic pu, logic pd, logic [3:0] v,
                                          logic [3:0] cur, output string tag);
    logic ur, dr;
    ur = u & ~pu;
    dr = d & ~pd;
    if (c)               begin tag = "R1/R11"; return 4'd0;    end
    if (!l)              begin tag = "R2/R11"; return v;       end
    if (ur && dr)        begin tag = "R6";     return cur;     end
    if (ur && d)         begin tag = (cur == 4'd15) ? "R5" : "R3"; return cur + 4'd1; end
    if (dr && u)         begin tag = (cur == 4'd0)  ? "R5" : "R4"; return cur - 4'd1; end
    tag = "R7";
    return cur;
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle at the falling edge, predict, then check at the next falling edge
  task automatic step(logic c, logic l, logic u, logic d, logic [3:0] v);
    string tag;
    @(negedge clk);
    clear = c; load_n = l; up_stb = u; dn_stb = d; din = v;
    m_cnt = next_cnt(c, l, u, d, m_pu, m_pd, v, m_cnt, tag);
    m_tag = tag;
    m_carry  = ~((m_cnt == 4'd15) & ~u);
    m_borrow = ~((m_cnt == 4'd0) & ~d);
    m_pu = u;
    m_pd = d;
    @(negedge clk);
    check(m_tag, cnt, m_cnt);
    check("R8", {3'b0, carry_n}, {3'b0, m_carry});
    check("R9", {3'b0, borrow_n}, {3'b0, m_borrow});
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state, strobes held high through reset do not count
    check("R10", cnt, 4'd0);
    check("R10", {3'b0, carry_n}, 4'd1);
    check("R10", {3'b0, borrow_n}, 4'd1);
    step(0, 1, 1, 1, 4'd9);
    // R2: load a value, then count up through the wrap (R5, R3, R8)
    step(0, 0, 1, 1, 4'd14);
    step(0, 1, 0, 1, 4'd0);
    step(0, 1, 1, 1, 4'd0);          // R3 rise to 15
    step(0, 1, 0, 1, 4'd0);          // R8 carry low at 15 with up low
    step(0, 1, 1, 1, 4'd0);          // R5 wrap to 0
    // R4 / R5 / R9: count down across zero
    step(0, 1, 1, 0, 4'd0);          // R9 borrow low at 0 with down low
    step(0, 1, 1, 1, 4'd0);          // R5 wrap to 15
    // R6: both strobes rise together
    step(0, 1, 0, 0, 4'd0);
    step(0, 1, 1, 1, 4'd0);
    // R7: up rise while down stays low is ignored
    step(0, 1, 0, 0, 4'd0);
    step(0, 1, 1, 0, 4'd0);
    // R11: clear wins over load and over a qualified rise
    step(0, 1, 0, 1, 4'd0);
    step(1, 0, 1, 1, 4'd7);
    // R11: load wins over a qualified rise
    step(0, 1, 0, 1, 4'd0);
    step(0, 0, 1, 1, 4'd5);
    // Seeded random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic c, l;
      r = int'($urandom % 32);
      c = (r == 0);
      l = !(r == 1 || r == 2);
      step(c, l, ($urandom % 10) < 6, ($urandom % 10) < 6, 4'($urandom));
    end
    // R10: synchronous reset mid-run with the strobes high
    @(negedge clk);
    rst = 1'b1; up_stb = 1'b1; dn_stb = 1'b1; clear = 1'b0; load_n = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 4'd0; m_carry = 1'b1; m_borrow = 1'b1; m_pu = 1'b1; m_pd = 1'b1;
    check("R10", cnt, 4'd0);
    step(0, 1, 1, 1, 4'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule